// File: doc/BRIEF.md
# Heartbeat Interval Timer

This block measures the spacing between successive heartbeats in units of the system clock. Its input is a single conditioned beat line that an external front end has already squared into clean logic levels. Every rising edge of that line becomes exactly one detection. A free-running interval counter measures the time between detections. At each detection the count is captured into an interval register and the counter starts again from zero.

Downstream logic uses three results. The first is the captured interval, with a one-cycle strobe that marks each new capture and starts a rate divider. The second is a flag that is high while no beat has arrived for so long that the counter is pinned at its ceiling, so the display can show a rate of zero. The third is an error flag that is high when the last captured interval is too short to be a real heartbeat. With the defaults the counter is 11 bits wide, and with the intended 960 Hz clock it spans a little over two seconds.

Top module: `beat_interval_meter`

## Requirements
- R1: A detection occurs only in a cycle where the sampled beat input is 1 and its value sampled one clock earlier was 0. A level held high for many cycles causes exactly one capture.
- R2: The interval counter is CNT_W bits wide (11 by default). It counts up by one per clock and holds at its ceiling 2**CNT_W-1 (2047) instead of wrapping. A detection after saturation captures 2047.
- R3: `no_beat_o` is 1 exactly while the interval counter holds its ceiling value, and 0 otherwise.
- R4: On a detection the counter's current value is loaded into `interval_o`, and the counter is 0 on the next cycle. With rises detected P clocks apart, the capture is P-1. `interval_o` is unchanged between detections.
- R5: `short_o` is updated only at a capture. It is 1 when the captured value is below MIN_INTERVAL (230 by default) and 0 otherwise. A capture of 229 sets it and a capture of 230 clears it.
- R6: `valid_o` is high for exactly one cycle, in the cycle where the new `interval_o` value first appears, and is low in every other cycle.
- R7: A synchronous active-high `rst` clears the counter, the interval register and the delayed beat sample. While it is held and after it is released, `interval_o`=0, `valid_o`=0, `short_o`=0 and `no_beat_o`=0 until new activity occurs.
- R8: When a detection coincides with a saturated counter, the capture and restart take effect, and `no_beat_o` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_i | input | 1 | Conditioned beat level from the analog front end |
| interval_o | output | CNT_W | Last captured beat interval in clock cycles |
| valid_o | output | 1 | One-cycle strobe marking a new capture |
| short_o | output | 1 | Last captured interval below MIN_INTERVAL |
| no_beat_o | output | 1 | Counter saturated; rate should read zero |

## Verification
The hardest case to reach is a detection that lands on an already saturated counter. This case exercises both the ceiling hold and the priority of capture over saturation. The stimulus reaches it by holding the beat line low for well over 2047 cycles, so that the counter has parked at its ceiling, and then raising the line once. The threshold edge is reached with rise-to-rise periods of 230 and 231 clocks, which give captures of 229 and 230.

// File: rtl/bim_pkg.sv
package bim_pkg;
   localparam int DEF_CNT_W        = 11;
   localparam int DEF_MIN_INTERVAL = 230;

   function automatic int ceiling_of(input int width);
      return (1 << width) - 1;
   endfunction
endpackage

// File: rtl/bim_edge_detect.sv
module bim_edge_detect (
   input  logic clk,
   input  logic rst,
   input  logic level_i,
   output logic rise_o
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (rst) level_q <= 1'b0;
      else     level_q <= level_i;
   end

   assign rise_o = level_i & ~level_q;

   // R1: a detection cannot repeat on the following cycle
   a_r1_single_rise: assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o);
endmodule

// File: rtl/bim_interval_counter.sv
module bim_interval_counter #(
   parameter int CNT_W = bim_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             sat_o
);
   localparam logic [CNT_W-1:0] CEIL = CNT_W'(bim_pkg::ceiling_of(CNT_W));

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
         $error("bim_interval_counter: CNT_W out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)          cnt_o <= '0;
      else if (clr_i)   cnt_o <= '0;
      else if (!sat_o)  cnt_o <= cnt_o + 1'b1;
   end

   assign sat_o = (cnt_o == CEIL);

   // R2: once parked at the ceiling the count stays there without a detection
   a_r2_hold_ceiling: assert property (@(posedge clk) disable iff (rst)
      (sat_o && !clr_i) |=> (cnt_o == CEIL));
   // R4: a detection restarts the count from zero
   a_r4_restart: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/bim_capture.sv
module bim_capture #(
   parameter int CNT_W        = bim_pkg::DEF_CNT_W,
   parameter int MIN_INTERVAL = bim_pkg::DEF_MIN_INTERVAL
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] interval_o,
   output logic             valid_o,
   output logic             short_o
);
   logic short_d;

   generate
      if (MIN_INTERVAL < 0 || MIN_INTERVAL > bim_pkg::ceiling_of(CNT_W)) begin : g_bad_min
         $error("bim_capture: MIN_INTERVAL does not fit CNT_W");
      end
      if (MIN_INTERVAL == 0) begin : g_no_floor
         assign short_d = 1'b0;
      end else begin : g_floor
         localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_INTERVAL);
         assign short_d = (cnt_i < FLOOR);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         interval_o <= '0;
         valid_o    <= 1'b0;
         short_o    <= 1'b0;
      end else begin
         valid_o <= load_i;
         if (load_i) begin
            interval_o <= cnt_i;
            short_o    <= short_d;
         end
      end
   end

   // R5: the error flag moves only at a capture
   a_r5_short_stable: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(short_o));
   // R4: the interval holds between captures
   a_r4_interval_hold: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(interval_o));
   // R6: the strobe is never two cycles long
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);
endmodule

// File: rtl/beat_interval_meter.sv
module beat_interval_meter #(
   parameter int CNT_W        = bim_pkg::DEF_CNT_W,
   parameter int MIN_INTERVAL = bim_pkg::DEF_MIN_INTERVAL
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             beat_i,
   output logic [CNT_W-1:0] interval_o,
   output logic             valid_o,
   output logic             short_o,
   output logic             no_beat_o
);
   logic             rise;
   logic [CNT_W-1:0] cnt;
   logic             sat;

   bim_edge_detect u_edge (
      .clk     (clk),
      .rst     (rst),
      .level_i (beat_i),
      .rise_o  (rise)
   );

   bim_interval_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr_i (rise),
      .cnt_o (cnt),
      .sat_o (sat)
   );

   bim_capture #(.CNT_W(CNT_W), .MIN_INTERVAL(MIN_INTERVAL)) u_cap (
      .clk        (clk),
      .rst        (rst),
      .load_i     (rise),
      .cnt_i      (cnt),
      .interval_o (interval_o),
      .valid_o    (valid_o),
      .short_o    (short_o)
   );

   assign no_beat_o = sat;

   // R8: a detection on a saturated counter clears the zero-rate flag next cycle
   a_r8_collision: assert property (@(posedge clk) disable iff (rst)
      (no_beat_o && rise) |=> !no_beat_o);
   // R3: the flag cannot appear without a full run of quiet cycles
   a_r3_no_jump: assert property (@(posedge clk) disable iff (rst)
      $rose(no_beat_o) |-> $past(!rise));
   // R6: the strobe follows a detection by exactly one cycle
   a_r6_strobe_follows: assert property (@(posedge clk) disable iff (rst)
      rise |=> valid_o);
endmodule

// File: tb/beat_interval_meter_test.sv
module beat_interval_meter_test;
   localparam int CEIL = 2047;
   localparam int FLOOR = 230;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        beat = 1'b0;
   logic [10:0] interval;
   logic        valid, short_f, no_beat;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   int m_cnt = 0, m_int = 0;
   bit m_prev = 0, m_valid = 0, m_short = 0;
   int valid_seen = 0;

   always #4 clk = ~clk;

   beat_interval_meter uut (
      .clk(clk), .rst(rst), .beat_i(beat),
      .interval_o(interval), .valid_o(valid),
      .short_o(short_f), .no_beat_o(no_beat)
   );

   // behavioural reference, stepped on each rising edge
   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_int = 0; m_prev = 0; m_valid = 0; m_short = 0;
      end else begin
         m_valid = beat && !m_prev;
         if (m_valid) begin
            m_int   = m_cnt;
            m_short = (m_cnt < FLOOR);
            m_cnt   = 0;
         end else if (m_cnt < CEIL) begin
            m_cnt = m_cnt + 1;
         end
         m_prev = beat;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         check(interval == 11'(m_int), "R4 interval", int'(interval), m_int);
         check(valid == m_valid,       "R6 strobe",   int'(valid),    int'(m_valid));
         check(short_f == m_short,     "R5 short",    int'(short_f),  int'(m_short));
         check(no_beat == (m_cnt == CEIL), "R3 no_beat", int'(no_beat), int'(m_cnt == CEIL));
         if (valid) valid_seen++;
      end
   end

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // rises spaced 'period' clocks apart, each held high for 'high' clocks
   task automatic train(input int period, input int high, input int reps);
      for (int i = 0; i < reps; i++) begin
         beat = 1'b1;
         wait_cycles(high);
         beat = 1'b0;
         wait_cycles(period - high);
      end
   endtask

   initial begin
      wait_cycles(3);
      // R7: reset state
      check(interval == 0 && !valid && !short_f && !no_beat, "R7 reset", int'(interval), 0);
      rst = 1'b0;
      wait_cycles(2);
      check(!valid && !short_f && !no_beat, "R7 after release", int'(no_beat), 0);

      // R1: long high levels, one capture per rise
      valid_seen = 0;
      train(500, 40, 4);
      check(valid_seen == 4, "R1 one capture per rise", valid_seen, 4);
      check(interval == 499, "R4 capture of period-1", int'(interval), 499);

      // R5: threshold boundary
      train(231, 3, 2);
      check(interval == 230 && !short_f, "R5 at floor", int'(interval), 230);
      train(230, 3, 2);
      check(interval == 229 && short_f, "R5 below floor", int'(short_f), 1);
      train(100, 1, 2);
      check(short_f == 1, "R5 short train", int'(short_f), 1);
      train(900, 5, 2);
      check(short_f == 0, "R5 recovers", int'(short_f), 0);

      // R2/R3: long silence saturates the counter
      wait_cycles(3000);
      check(no_beat == 1, "R3 saturated", int'(no_beat), 1);
      check(interval == 899, "R2 interval held while saturated", int'(interval), 899);

      // R8: rise on a saturated counter
      beat = 1'b1;
      wait_cycles(1);
      check(valid == 1 && interval == CEIL, "R2 capture at ceiling", int'(interval), CEIL);
      check(no_beat == 0, "R8 flag clears", int'(no_beat), 0);
      beat = 1'b0;
      wait_cycles(20);

      // R7: mid-run reset
      train(300, 2, 1);
      rst = 1'b1;
      wait_cycles(2);
      check(interval == 0 && !valid && !short_f && !no_beat, "R7 mid-run reset", int'(interval), 0);
      rst = 1'b0;
      train(400, 10, 2);
      check(interval == 399, "R4 after reset", int'(interval), 399);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule